// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Timing Engine

This block is the host-side sequencer that times each 16-bit word exchanged with an ATA drive. It works from counts held in clock cycles, so no mode timing is built into the logic. Software provides one count for the strobe-active phase, one for the recovery phase and one for the read-sample offset. Values for PIO or for Multiword DMA modes 0, 1 and 2 (minimum cycles of 480, 150 and 120 ns; minimum 16-bit strobe widths of 215, 80 and 70 ns; read data valid up to 150, 60 and 50 ns after the read strobe) are converted into these counts.

The system side is a request/acknowledge port. The requester holds `sys_req` with direction and data until `sys_ack` pulses, and may present the next word in that same cycle. The drive side is modelled at pin level. It has active-low read and write strobes, a write data bus with its enable, a read data bus, a drive-ready input that can stretch a PIO strobe, and a DMA request with an active-low grant. Write data changes on the same clock edge that activates the write strobe. It then stays put until the next active write edge, so the drive latching on the inactive edge has a full recovery period of hold margin. In Multiword DMA the grant is taken when the drive requests and a word is pending. It is held across consecutive words and dropped when the current cycle's recovery ends.

Top module: `ata_xfer_timer`

## Requirements
- R1: While reset is applied and in the first cycle after it, both strobes and the DMA grant are high, `sys_ack` is 0 and `dd_oe` is 0.
- R2: With no stretch, a strobe stays low for exactly `cfg_active` clock cycles, where a count of 0 acts as 1. The read and write strobes are never low together.
- R3: Each strobe pulse is followed by `cfg_recover` high cycles, where 0 acts as 1. Back-to-back words start `cfg_active+cfg_recover+1` cycles apart in PIO and `cfg_active+cfg_recover` cycles apart inside a DMA burst.
- R4: For a write, `dd_out` takes the new word on the clock edge that drives `wr_strobe_n` low, and `dd_oe` is 1 from then on. `dd_out` changes at no other edge.
- R5: Counting the clock edges while the read strobe is low from 1, the read word is the `dd_in` value at edge `cfg_sample+1`. If `cfg_sample` is at least `cfg_active-1`, the read word is the value at the edge that ends the strobe.
- R6: In PIO mode (`mode_dma`=0), if `drive_ready` is 0 when the active count has run out, the strobe stays low. It rises at the first edge at which `drive_ready` is 1.
- R7: In DMA mode (`mode_dma`=1), `drive_ready` has no effect on strobe width.
- R8: In DMA mode, no cycle starts while `dma_req` is 0. When `dma_req` and `sys_req` are both 1 in idle, `dma_grant_n` falls, and the strobe falls one clock later.
- R9: At the end of recovery in DMA mode, the next word starts without releasing the grant if `dma_req` and `sys_req` are both 1. Otherwise `dma_grant_n` rises on that edge.
- R10: `sys_ack` is a single-cycle pulse on the edge that ends each strobe, one per word. `sys_rdata` is valid from that pulse on.
- R11: In PIO mode `dma_grant_n` stays high whatever `dma_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_dma | input | 1 | 1 selects Multiword DMA, 0 selects PIO; held static while a word is in flight |
| cfg_active | input | CNT_W | Strobe-active count in clocks |
| cfg_recover | input | CNT_W | Strobe-recovery count in clocks |
| cfg_sample | input | CNT_W | Read-sample offset in clocks from strobe fall |
| sys_req | input | 1 | A word is pending |
| sys_write | input | 1 | 1 for a write to the drive, 0 for a read |
| sys_wdata | input | DATA_W | Word to write |
| sys_ack | output | 1 | One-cycle completion pulse |
| sys_rdata | output | DATA_W | Word read from the drive |
| rd_strobe_n | output | 1 | Read strobe to the drive, active low |
| wr_strobe_n | output | 1 | Write strobe to the drive, active low |
| dd_out | output | DATA_W | Write data towards the drive |
| dd_oe | output | 1 | Data bus drive enable |
| dd_in | input | DATA_W | Read data from the drive |
| drive_ready | input | 1 | Drive ready; low stretches a PIO strobe |
| dma_req | input | 1 | DMA request from the drive |
| dma_grant_n | output | 1 | DMA acknowledge to the drive, active low |

## Verification
Two events share a single clock edge. The write strobe goes active on the same edge that puts the new word on the data bus. Inside a DMA burst, the edge that ends recovery is also the edge that starts the next word, which the requester set up while the acknowledge pulse was high. The bench provokes both by running back-to-back words in each mode, with the next word presented while the acknowledge is high. It judges the result from pin observations: the bus value seen at the first low sample of each write strobe, no bus change at any other edge, and the gap between strobe falls. A monitor that follows the grant shows whether a burst continued or released.

// File: rtl/ata_seq_pkg.sv
// Shared definitions for the ATA word timing engine.
package ata_seq_pkg;
    // Phase of one word cycle on the drive side.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_GRANT   = 2'd1,
        PH_ACTIVE  = 2'd2,
        PH_RECOVER = 2'd3
    } phase_e;
endpackage

// File: rtl/ata_cycle_fsm.sv
// Word cycle sequencer: steps idle -> (grant) -> active -> recover.
// Outputs both strobes, the DMA grant and the completion pulse as registers.
// It also makes the launch and capture enables for the data path.
// Assumes mode_dma stays static while a word is in flight and that
// sys_req, sys_write and sys_wdata are held until the completion pulse.
module ata_cycle_fsm
    import ata_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_dma,
    input  logic [CNT_W-1:0] cfg_active,
    input  logic [CNT_W-1:0] cfg_recover,
    input  logic [CNT_W-1:0] cfg_sample,
    input  logic             sys_req,
    input  logic             sys_write,
    input  logic             dma_req,
    input  logic             drive_ready,
    output logic             rd_strobe_n,
    output logic             wr_strobe_n,
    output logic             grant_n,
    output logic             word_done,
    output logic             launch,
    output logic             capture
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_act;
    logic [CNT_W-1:0] last_rec;
    logic             cur_write;
    logic             act_end;
    logic             rec_end;
    logic             start_pio;
    logic             start_dma;
    logic             chain;

    // Final count index of each phase; a zero count behaves as one.
    always_comb begin
        last_act = (cfg_active  == '0) ? '0 : cfg_active  - 1'b1;
        last_rec = (cfg_recover == '0) ? '0 : cfg_recover - 1'b1;
    end

    // Phase exit and start conditions.
    always_comb begin
        act_end   = (phase == PH_ACTIVE) && (cnt == last_act) && (mode_dma || drive_ready);
        rec_end   = (phase == PH_RECOVER) && (cnt == last_rec);
        start_pio = (phase == PH_IDLE) && !mode_dma && sys_req;
        start_dma = (phase == PH_IDLE) && mode_dma && sys_req && dma_req;
        chain     = rec_end && mode_dma && sys_req && dma_req;
        launch    = start_pio || (phase == PH_GRANT) || chain;
        capture   = (phase == PH_ACTIVE) && !cur_write && (cnt <= cfg_sample);
    end

    // Phase register, counter, strobes and grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            cnt         <= '0;
            rd_strobe_n <= 1'b1;
            wr_strobe_n <= 1'b1;
            grant_n     <= 1'b1;
            word_done   <= 1'b0;
            cur_write   <= 1'b0;
        end else begin
            word_done <= act_end;
            case (phase)
                PH_IDLE: begin
                    if (start_dma) begin
                        phase   <= PH_GRANT;
                        grant_n <= 1'b0;
                    end
                end
                PH_GRANT: ;
                PH_ACTIVE: begin
                    if (act_end) begin
                        phase       <= PH_RECOVER;
                        cnt         <= '0;
                        rd_strobe_n <= 1'b1;
                        wr_strobe_n <= 1'b1;
                    end else if (cnt != last_act) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RECOVER: begin
                    if (rec_end) begin
                        phase   <= PH_IDLE;
                        grant_n <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
            if (launch) begin
                phase       <= PH_ACTIVE;
                cnt         <= '0;
                cur_write   <= sys_write;
                rd_strobe_n <= sys_write;
                wr_strobe_n <= !sys_write;
                if (chain) grant_n <= 1'b0;
            end
        end
    end

    // R10
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done)
        else $error("completion pulse longer than one cycle");

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe_n || wr_strobe_n)
        else $error("both strobes active");
endmodule

// File: rtl/ata_data_path.sv
// Data path: launches write data on the edge that activates the write
// strobe and holds it until the next launch. It also captures read data
// while the sequencer's capture enable is high.
// Assumes launch and capture come from the cycle sequencer.
module ata_data_path #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              sys_write,
    input  logic [DATA_W-1:0] sys_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic [DATA_W-1:0] rdata
);
    // Write word and bus enable, updated only when a word is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dd_out <= '0;
            dd_oe  <= 1'b0;
        end else if (launch) begin
            dd_oe <= sys_write;
            if (sys_write) dd_out <= sys_wdata;
        end
    end

    // Read word, refreshed each capture cycle; the last capture wins.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (capture) rdata <= dd_in;
    end
endmodule

// File: rtl/ata_xfer_timer.sv
// Top of the ATA PIO / Multiword DMA word timing engine.
// Joins the cycle sequencer and the data path. All phase lengths come from
// the cfg_* counts, in clock cycles.
// Assumes mode_dma and cfg_* are static while a word is in flight.
module ata_xfer_timer #(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dma,
    input  logic [CNT_W-1:0]  cfg_active,
    input  logic [CNT_W-1:0]  cfg_recover,
    input  logic [CNT_W-1:0]  cfg_sample,
    input  logic              sys_req,
    input  logic              sys_write,
    input  logic [DATA_W-1:0] sys_wdata,
    output logic              sys_ack,
    output logic [DATA_W-1:0] sys_rdata,
    output logic              rd_strobe_n,
    output logic              wr_strobe_n,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] dd_in,
    input  logic              drive_ready,
    input  logic              dma_req,
    output logic              dma_grant_n
);
    logic launch;
    logic capture;

    ata_cycle_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_dma    (mode_dma),
        .cfg_active  (cfg_active),
        .cfg_recover (cfg_recover),
        .cfg_sample  (cfg_sample),
        .sys_req     (sys_req),
        .sys_write   (sys_write),
        .dma_req     (dma_req),
        .drive_ready (drive_ready),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .grant_n     (dma_grant_n),
        .word_done   (sys_ack),
        .launch      (launch),
        .capture     (capture)
    );

    ata_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .sys_write (sys_write),
        .sys_wdata (sys_wdata),
        .capture   (capture),
        .dd_in     (dd_in),
        .dd_out    (dd_out),
        .dd_oe     (dd_oe),
        .rdata     (sys_rdata)
    );

    // R4
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(wr_strobe_n) |-> $stable(dd_out))
        else $error("write data moved outside an active write edge");

    // R8
    grant_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_grant_n) |=> ($fell(rd_strobe_n) || $fell(wr_strobe_n)))
        else $error("strobe did not follow grant by one clock");
endmodule

// File: tb/ata_xfer_timer_test.sv
// Self-checking bench for ata_xfer_timer: a vector table of back-to-back
// word pairs, then directed reset, stretch, grant and corner tests.
module ata_xfer_timer_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_dma = 1'b0;
    logic [7:0]  cfg_active = 8'd1;
    logic [7:0]  cfg_recover = 8'd1;
    logic [7:0]  cfg_sample = 8'd0;
    logic        sys_req = 1'b0;
    logic        sys_write = 1'b0;
    logic [15:0] sys_wdata = '0;
    logic        sys_ack;
    logic [15:0] sys_rdata;
    logic        rd_strobe_n;
    logic        wr_strobe_n;
    logic [15:0] dd_out;
    logic        dd_oe;
    logic [15:0] dd_in = '0;
    logic        drive_ready = 1'b1;
    logic        dma_req = 1'b0;
    logic        dma_grant_n;

    int checks = 0;
    int fails  = 0;
    int words  = 0;

    ata_xfer_timer uut (
        .clk(clk), .rst_n(rst_n), .mode_dma(mode_dma),
        .cfg_active(cfg_active), .cfg_recover(cfg_recover), .cfg_sample(cfg_sample),
        .sys_req(sys_req), .sys_write(sys_write), .sys_wdata(sys_wdata),
        .sys_ack(sys_ack), .sys_rdata(sys_rdata),
        .rd_strobe_n(rd_strobe_n), .wr_strobe_n(wr_strobe_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in),
        .drive_ready(drive_ready), .dma_req(dma_req), .dma_grant_n(dma_grant_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pin monitor, sampled on falling clock edges.
    logic [15:0] n = '0;
    logic [15:0] fall_n = '0, prev_fall = '0, last_period = '0, fall_dd = '0;
    logic [15:0] prev_dd = '0;
    int   low_cnt = 0, last_width = 0, grant_run = 0, lead = 0;
    int   grant_rises = 0, grant_low_total = 0, viol = 0, ack_cnt = 0, dbl = 0;
    logic prev_low = 1'b0, prev_wr = 1'b1, prev_grant = 1'b1, prev_ack = 1'b0;
    always @(negedge clk) begin
        n     <= n + 1'b1;
        dd_in <= n + 1'b1;
        if (rst_n) begin
            if ((!rd_strobe_n || !wr_strobe_n) && !prev_low) begin
                fall_n      <= n;
                fall_dd     <= dd_out;
                last_period <= n - prev_fall;
                prev_fall   <= n;
                low_cnt     <= 1;
                lead        <= grant_run;
            end else if (!rd_strobe_n || !wr_strobe_n) begin
                low_cnt <= low_cnt + 1;
            end
            if (rd_strobe_n && wr_strobe_n && prev_low) last_width <= low_cnt;
            grant_run <= dma_grant_n ? 0 : grant_run + 1;
            if (!dma_grant_n) grant_low_total <= grant_low_total + 1;
            if (dma_grant_n && !prev_grant) grant_rises <= grant_rises + 1;
            if (dd_out != prev_dd && !(!wr_strobe_n && prev_wr)) viol <= viol + 1;
            if (sys_ack) ack_cnt <= ack_cnt + 1;
            if (sys_ack && prev_ack) dbl <= dbl + 1;
        end
        prev_low   <= !rd_strobe_n || !wr_strobe_n;
        prev_wr    <= wr_strobe_n;
        prev_grant <= dma_grant_n;
        prev_ack   <= sys_ack;
        prev_dd    <= dd_out;
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_ack();
        int k = 0;
        @(negedge clk);
        while (!sys_ack && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (!sys_ack) chk("R10 completion timeout", 0, 1);
        else words++;
    endtask

    // Check one finished word against the requirements.
    task automatic check_word(input bit wr, input int d, input int act, input int smp);
        int exp_s;
        chk("R2 strobe width", last_width, (act == 0) ? 1 : act);
        if (wr) begin
            chk("R4 data at write edge", int'(fall_dd), d & 16'hFFFF);
            chk("R4 bus enable", int'(dd_oe), 1);
        end else begin
            exp_s = (smp < act - 1) ? smp : last_width - 1;
            chk("R5 read sample", int'(sys_rdata), (int'(fall_n) + 1 + exp_s) & 16'hFFFF);
        end
    endtask

    // Two back-to-back words with one timing set.
    task automatic run_pair(input bit dma, input bit wr, input int act, input int rec,
                            input int smp, input int d);
        int r0;
        @(negedge clk);
        mode_dma = dma; cfg_active = act[7:0]; cfg_recover = rec[7:0];
        cfg_sample = smp[7:0]; dma_req = dma; drive_ready = 1'b1;
        sys_write = wr; sys_wdata = d[15:0]; sys_req = 1'b1;
        r0 = grant_rises;
        wait_ack();
        sys_wdata = ~d[15:0];
        #1;
        check_word(wr, d, act, smp);
        if (dma) chk("R8 grant leads strobe", lead, 1);
        wait_ack();
        sys_req = 1'b0; dma_req = 1'b0;
        #1;
        check_word(wr, ~d, act, smp);
        chk("R3 word period", int'(last_period), act + rec + (dma ? 0 : 1));
        if (dma) chk("R9 grant held in burst", grant_rises, r0);
        repeat (rec + 3) @(negedge clk);
        chk("R9 grant released", int'(dma_grant_n), 1);
    endtask

    // dma, write, active, recover, sample, data
    localparam logic [41:0] VEC [6] = '{
        {1'b0, 1'b1, 8'd4, 8'd3, 8'd0, 16'h1234},
        {1'b0, 1'b0, 8'd5, 8'd2, 8'd2, 16'h0000},
        {1'b0, 1'b0, 8'd3, 8'd1, 8'd7, 16'h0000},
        {1'b1, 1'b1, 8'd2, 8'd2, 8'd0, 16'hBEEF},
        {1'b1, 1'b0, 8'd6, 8'd4, 8'd3, 16'h0000},
        {1'b1, 1'b1, 8'd1, 8'd1, 8'd0, 16'h5A5A}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        chk("watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int g0, r0;
        repeat (4) @(negedge clk);
        chk("R1 read strobe in reset", int'(rd_strobe_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 read strobe", int'(rd_strobe_n), 1);
        chk("R1 write strobe", int'(wr_strobe_n), 1);
        chk("R1 grant", int'(dma_grant_n), 1);
        chk("R1 ack", int'(sys_ack), 0);
        chk("R1 bus enable", int'(dd_oe), 0);

        for (int i = 0; i < 6; i++) begin
            logic [41:0] v;
            v = VEC[i];
            run_pair(v[41], v[40], int'(v[39:32]), int'(v[31:24]), int'(v[23:16]), int'(v[15:0]));
        end

        // R2: zero active count behaves as one
        @(negedge clk);
        mode_dma = 0; cfg_active = 0; cfg_recover = 1; sys_write = 1;
        sys_wdata = 16'h0F0F; sys_req = 1;
        wait_ack(); sys_req = 0; #1;
        chk("R2 zero count width", last_width, 1);

        // R6: PIO stretch by drive_ready, late sample follows the stretch
        @(negedge clk);
        cfg_active = 3; cfg_recover = 2; cfg_sample = 9; sys_write = 0;
        drive_ready = 0; sys_req = 1;
        do @(negedge clk); while (rd_strobe_n);
        repeat (6) @(negedge clk);
        drive_ready = 1;
        wait_ack(); sys_req = 0; #1;
        chk("R6 stretched width", last_width, 7);
        chk("R6 R5 sample at stretched end", int'(sys_rdata), (int'(fall_n) + 7) & 16'hFFFF);

        // R7: DMA ignores drive_ready
        repeat (4) @(negedge clk);
        mode_dma = 1; dma_req = 1; drive_ready = 0; cfg_active = 3; cfg_recover = 1;
        cfg_sample = 0; sys_write = 0; sys_req = 1;
        wait_ack(); sys_req = 0; dma_req = 0; #1;
        chk("R7 DMA width ignores ready", last_width, 3);
        drive_ready = 1;

        // R11: PIO ignores dma_req
        repeat (6) @(negedge clk);
        g0 = grant_low_total;
        mode_dma = 0; dma_req = 1; cfg_active = 2; sys_write = 1;
        sys_wdata = 16'hC3C3; sys_req = 1;
        wait_ack(); sys_req = 0; #1;
        chk("R11 PIO width", last_width, 2);
        repeat (3) @(negedge clk);
        chk("R11 no grant in PIO", grant_low_total - g0, 0);
        dma_req = 0;

        // R8: DMA waits for dma_req
        repeat (3) @(negedge clk);
        mode_dma = 1; cfg_active = 2; cfg_recover = 2; sys_write = 1;
        sys_wdata = 16'h7777; sys_req = 1;
        repeat (10) @(negedge clk);
        chk("R8 no strobe without request", int'(wr_strobe_n), 1);
        chk("R8 no grant without request", int'(dma_grant_n), 1);
        dma_req = 1;
        wait_ack(); #1;
        chk("R8 grant lead", lead, 1);
        chk("R4 data at write edge", int'(fall_dd), 16'h7777);

        // R9: request drops mid-burst, grant released, word waits
        r0 = grant_rises;
        dma_req = 0; sys_wdata = 16'h8888;
        repeat (8) @(negedge clk);
        chk("R9 release on dropped request", grant_rises, r0 + 1);
        chk("R9 next word waits", int'(wr_strobe_n), 1);
        dma_req = 1;
        wait_ack(); sys_req = 0; dma_req = 0; #1;
        chk("R9 resumed word data", int'(fall_dd), 16'h8888);
        repeat (6) @(negedge clk);

        chk("R4 no bus change off write edge", viol, 0);
        chk("R10 ack pulses single", dbl, 0);
        chk("R10 one ack per word", ack_cnt, words);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule